// File: doc/BRIEF.md
# Link-Up Monitor with Speed-Change Stall Recovery

This block decides when a serial link has finished training. It watches two 32-bit debug status words from the link-training logic. The link counts as up only when the second word shows link-up and does not show training in progress. Until that holds, the block runs a bounded loop of checks. On each check where the link is still down, it reads a receiver status register inside the PHY through a simple command/acknowledge port. The training state machine can stall during a speed change: it sits in the receiver-lock recovery state while the receiver reports no valid data. When the block sees that, it briefly forces two receiver override bits (data enable and PLL enable) in a PHY register, using read-modify-write, and then releases them.

The surrounding control raises `enable` to start monitoring. It reads `link_up`, or `link_fail` once the retry budget is spent. On failure the block keeps a snapshot of both debug words for inspection. The PHY register access engine and the training state machine are outside the block. Each one is reached only through the ports.

Top module: `lw_link_watch`

## Requirements
- R1: After reset, `link_up`, `link_fail` and `phy_req` are low and both failure snapshots are zero.
- R2: A check finds the link up only when bit 4 of `dbg_status1` is 1 and bit 29 of `dbg_status1` is 0. A check that finds the link up raises `link_up` and issues no PHY command. While `link_up` is high, `phy_req` stays low.
- R3: Every check that finds the link down, except the last allowed one, issues exactly one PHY read (`phy_wr`=0) of address 0x100D. The training state used by that check is `dbg_status0[5:0]`, sampled in the check cycle. Bit 0 of the read data is the receiver-valid flag.
- R4: Recovery runs when the sampled state equals RCVRLOCK_CODE (default 6'h0D) and the receiver-valid flag is 0. It reads address 0x1005 and writes back the value OR 0x0028, which sets bit 5 (data enable) and bit 3 (PLL enable). It then waits at least HOLD_CYC cycles, reads 0x1005 again, and writes back that value AND NOT 0x0028. In every other case no command to 0x1005 is issued.
- R5: The first PHY command of one check starts at least RECHECK_CYC cycles after the first PHY command of the previous check.
- R6: The MAX_CHECKS-th check that finds the link down raises `link_fail` and issues no PHY command. `fail_snap0` and `fail_snap1` capture both debug words from that cycle. The snapshots then stay unchanged, even after `enable` falls, until the next failure or reset.
- R7: Once `link_up` is high, it stays high while `enable` stays high, even if the debug words later show the link down.
- R8: When `enable` is low, `link_up` and `link_fail` fall on the next cycle. If a recovery sequence has already started when `enable` falls, it completes, including the clearing write, before the block goes idle. No further check is started after that.
- R9: `phy_req` stays high with `phy_wr`, `phy_addr` and `phy_wdata` unchanged until a cycle in which `phy_ack` is high. `phy_req` falls in the following cycle, and at least one idle cycle separates consecutive commands.
- R10: `link_up` and `link_fail` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Start and keep monitoring while high |
| dbg_status0 | input | 32 | First debug word; training state in bits [5:0] |
| dbg_status1 | input | 32 | Second debug word; link-up bit 4, in-training bit 29 |
| phy_req | output | 1 | PHY command request, held until acknowledged |
| phy_wr | output | 1 | 1 for a write command, 0 for a read |
| phy_addr | output | 16 | PHY register address |
| phy_wdata | output | 16 | Write data |
| phy_ack | input | 1 | Command completed |
| phy_rdata | input | 16 | Read data, valid with `phy_ack` |
| link_up | output | 1 | Link is trained |
| link_fail | output | 1 | Retry budget exhausted |
| fail_snap0 | output | 32 | `dbg_status0` captured at failure |
| fail_snap1 | output | 32 | `dbg_status1` captured at failure |

## Verification
The bench builds the block with MAX_CHECKS=4, HOLD_CYC=8 and RECHECK_CYC=12 in place of the millisecond-scale defaults. With these values, a full exhaustion of the retry budget, the hold and re-check spacing, and several complete recovery sequences all fit in a few hundred cycles. A PHY model in the bench acknowledges after a fixed latency and keeps the override register, so the two override writes can be predicted from the requirements. Withdrawing `enable` in the middle of a recovery shows that the override bits are always released.

// File: rtl/lw_pkg.sv
package lw_pkg;

    localparam int PHY_AW = 16;
    localparam int PHY_DW = 16;

    localparam logic [PHY_AW-1:0] ADDR_RX_STATUS = 16'h100D;
    localparam logic [PHY_AW-1:0] ADDR_RX_OVRD  = 16'h1005;

    localparam int OVRD_DATA_EN_BIT = 5;
    localparam int OVRD_PLL_EN_BIT  = 3;
    localparam logic [PHY_DW-1:0] OVRD_MASK =
        (PHY_DW'(1) << OVRD_DATA_EN_BIT) | (PHY_DW'(1) << OVRD_PLL_EN_BIT);

    localparam int RX_VALID_BIT = 0;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CHECK,
        ST_RXV_GO,
        ST_RXV_WT,
        ST_RD1_GO,
        ST_RD1_WT,
        ST_SET_GO,
        ST_SET_WT,
        ST_HOLD,
        ST_RD2_GO,
        ST_RD2_WT,
        ST_CLR_GO,
        ST_CLR_WT,
        ST_PAUSE,
        ST_UP,
        ST_FAIL
    } lw_state_e;

    typedef struct packed {
        logic              wr;
        logic [PHY_AW-1:0] addr;
        logic [PHY_DW-1:0] wdata;
    } phy_cmd_t;

    function automatic phy_cmd_t mk_read(input logic [PHY_AW-1:0] a);
        phy_cmd_t c;
        c.wr    = 1'b0;
        c.addr  = a;
        c.wdata = '0;
        return c;
    endfunction

    function automatic phy_cmd_t mk_write(input logic [PHY_AW-1:0] a,
                                          input logic [PHY_DW-1:0] d);
        phy_cmd_t c;
        c.wr    = 1'b1;
        c.addr  = a;
        c.wdata = d;
        return c;
    endfunction

    function automatic logic [PHY_DW-1:0] ovrd_set(input logic [PHY_DW-1:0] v);
        return v | OVRD_MASK;
    endfunction

    function automatic logic [PHY_DW-1:0] ovrd_clr(input logic [PHY_DW-1:0] v);
        return v & ~OVRD_MASK;
    endfunction

endpackage

// File: rtl/lw_status_decode.sv
module lw_status_decode #(
    parameter int WORD_W    = 32,
    parameter int LINK_BIT  = 4,
    parameter int TRAIN_BIT = 29,
    parameter int STATE_W   = 6
) (
    input  logic [WORD_W-1:0]  dbg0,
    input  logic [WORD_W-1:0]  dbg1,
    output logic               link_ok,
    output logic [STATE_W-1:0] train_state
);
    // Link is trained only when up and no longer in training.
    assign link_ok     = dbg1[LINK_BIT] & ~dbg1[TRAIN_BIT];
    assign train_state = dbg0[STATE_W-1:0];
endmodule

// File: rtl/lw_timer.sv
module lw_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= val;
        end else if (cnt != '0) begin
            cnt <= cnt - W'(1);
        end
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/lw_retry.sv
module lw_retry #(
    parameter int MAX_CHECKS = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int CW = $clog2(MAX_CHECKS + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + CW'(1);
        end
    end

    assign last = (cnt >= CW'(MAX_CHECKS - 1));
endmodule

// File: rtl/lw_phy_port.sv
module lw_phy_port
    import lw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  phy_cmd_t          cmd,
    input  logic              ack,
    input  logic [PHY_DW-1:0] rdata,
    output logic              req,
    output phy_cmd_t          cmd_q,
    output logic              done,
    output logic [PHY_DW-1:0] rdata_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            req     <= 1'b0;
            cmd_q   <= '0;
            done    <= 1'b0;
            rdata_q <= '0;
        end else begin
            done <= 1'b0;
            if (go && !req) begin
                req   <= 1'b1;
                cmd_q <= cmd;
            end else if (req && ack) begin
                req     <= 1'b0;
                done    <= 1'b1;
                rdata_q <= rdata;
            end
        end
    end
endmodule

// File: rtl/lw_link_watch.sv
module lw_link_watch
    import lw_pkg::*;
#(
    parameter int          MAX_CHECKS    = 12,
    parameter int          HOLD_CYC      = 1000,
    parameter int          RECHECK_CYC   = 200000,
    parameter logic [5:0]  RCVRLOCK_CODE = 6'h0D
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        enable,
    input  logic [31:0] dbg_status0,
    input  logic [31:0] dbg_status1,
    output logic        phy_req,
    output logic        phy_wr,
    output logic [15:0] phy_addr,
    output logic [15:0] phy_wdata,
    input  logic        phy_ack,
    input  logic [15:0] phy_rdata,
    output logic        link_up,
    output logic        link_fail,
    output logic [31:0] fail_snap0,
    output logic [31:0] fail_snap1
);
    localparam int STATE_W = 6;
    localparam int TMAX    = (HOLD_CYC > RECHECK_CYC) ? HOLD_CYC : RECHECK_CYC;
    localparam int TW      = $clog2(TMAX + 1);

    lw_state_e            state, nxt;
    logic                 link_ok;
    logic [STATE_W-1:0]   train_state;
    logic [STATE_W-1:0]   state_q;
    logic                 go, done;
    phy_cmd_t             cmd, cmd_q;
    logic [PHY_DW-1:0]    rdata_q;
    logic                 tmr_load, tmr_zero;
    logic [TW-1:0]        tmr_val;
    logic                 r_clr, r_inc, r_last;
    logic                 snap_en;

    lw_status_decode #(
        .WORD_W(32), .LINK_BIT(4), .TRAIN_BIT(29), .STATE_W(STATE_W)
    ) u_dec (
        .dbg0(dbg_status0), .dbg1(dbg_status1),
        .link_ok(link_ok), .train_state(train_state)
    );

    lw_timer #(.W(TW)) u_tmr (
        .clk(clk), .rst(rst), .load(tmr_load), .val(tmr_val), .zero(tmr_zero)
    );

    lw_retry #(.MAX_CHECKS(MAX_CHECKS)) u_retry (
        .clk(clk), .rst(rst), .clr(r_clr), .inc(r_inc), .last(r_last)
    );

    lw_phy_port u_port (
        .clk(clk), .rst(rst), .go(go), .cmd(cmd), .ack(phy_ack),
        .rdata(phy_rdata), .req(phy_req), .cmd_q(cmd_q), .done(done),
        .rdata_q(rdata_q)
    );

    assign phy_wr    = cmd_q.wr;
    assign phy_addr  = cmd_q.addr;
    assign phy_wdata = cmd_q.wdata;

    always_comb begin
        nxt      = state;
        go       = 1'b0;
        cmd      = mk_read(ADDR_RX_STATUS);
        tmr_load = 1'b0;
        tmr_val  = TW'(RECHECK_CYC);
        r_clr    = 1'b0;
        r_inc    = 1'b0;
        snap_en  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                r_clr = 1'b1;
                if (enable) nxt = ST_CHECK;
            end
            ST_CHECK: begin
                if (!enable) begin
                    nxt = ST_IDLE;
                end else if (link_ok) begin
                    nxt = ST_UP;
                end else if (r_last) begin
                    nxt     = ST_FAIL;
                    snap_en = 1'b1;
                end else begin
                    r_inc = 1'b1;
                    nxt   = ST_RXV_GO;
                end
            end
            ST_RXV_GO: begin
                go  = 1'b1;
                cmd = mk_read(ADDR_RX_STATUS);
                nxt = ST_RXV_WT;
            end
            ST_RXV_WT: begin
                if (done) begin
                    if (state_q == RCVRLOCK_CODE && !rdata_q[RX_VALID_BIT]) begin
                        nxt = ST_RD1_GO;
                    end else begin
                        nxt      = ST_PAUSE;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(RECHECK_CYC);
                    end
                end
            end
            ST_RD1_GO: begin
                go  = 1'b1;
                cmd = mk_read(ADDR_RX_OVRD);
                nxt = ST_RD1_WT;
            end
            ST_RD1_WT: if (done) nxt = ST_SET_GO;
            ST_SET_GO: begin
                go  = 1'b1;
                cmd = mk_write(ADDR_RX_OVRD, ovrd_set(rdata_q));
                nxt = ST_SET_WT;
            end
            ST_SET_WT: begin
                if (done) begin
                    nxt      = ST_HOLD;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(HOLD_CYC);
                end
            end
            ST_HOLD: if (tmr_zero) nxt = ST_RD2_GO;
            ST_RD2_GO: begin
                go  = 1'b1;
                cmd = mk_read(ADDR_RX_OVRD);
                nxt = ST_RD2_WT;
            end
            ST_RD2_WT: if (done) nxt = ST_CLR_GO;
            ST_CLR_GO: begin
                go  = 1'b1;
                cmd = mk_write(ADDR_RX_OVRD, ovrd_clr(rdata_q));
                nxt = ST_CLR_WT;
            end
            ST_CLR_WT: begin
                if (done) begin
                    nxt      = ST_PAUSE;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(RECHECK_CYC);
                end
            end
            ST_PAUSE: begin
                if (!enable)       nxt = ST_IDLE;
                else if (tmr_zero) nxt = ST_CHECK;
            end
            ST_UP:   if (!enable) nxt = ST_IDLE;
            ST_FAIL: if (!enable) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            state_q    <= '0;
            fail_snap0 <= '0;
            fail_snap1 <= '0;
        end else begin
            state <= nxt;
            if (state == ST_CHECK) state_q <= train_state;
            if (snap_en) begin
                fail_snap0 <= dbg_status0;
                fail_snap1 <= dbg_status1;
            end
        end
    end

    assign link_up   = (state == ST_UP);
    assign link_fail = (state == ST_FAIL);
endmodule

// File: rtl/lw_link_watch_chk.sv
module lw_link_watch_chk (
    input logic        clk,
    input logic        rst,
    input logic        enable,
    input logic        phy_req,
    input logic        phy_wr,
    input logic [15:0] phy_addr,
    input logic [15:0] phy_wdata,
    input logic        phy_ack,
    input logic        link_up,
    input logic        link_fail,
    input logic [31:0] fail_snap0,
    input logic [31:0] fail_snap1
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!phy_req && !link_up && !link_fail));

    p_up_no_cmd_r2: assert property (@(posedge clk) disable iff (rst)
        link_up |-> !phy_req);

    p_fail_no_cmd_r6: assert property (@(posedge clk) disable iff (rst)
        link_fail |-> !phy_req);

    p_snap_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (link_fail && $past(link_fail)) |-> ($stable(fail_snap0) && $stable(fail_snap1)));

    p_off_release_r8: assert property (@(posedge clk) disable iff (rst)
        (!enable && (link_up || link_fail)) |=> (!link_up && !link_fail));

    p_req_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (phy_req && !phy_ack) |=>
            (phy_req && $stable(phy_wr) && $stable(phy_addr) && $stable(phy_wdata)));

    p_req_release_r9: assert property (@(posedge clk) disable iff (rst)
        (phy_req && phy_ack) |=> !phy_req);

    p_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(link_up && link_fail));
endmodule

bind lw_link_watch lw_link_watch_chk chk_i (
    .clk(clk), .rst(rst), .enable(enable), .phy_req(phy_req),
    .phy_wr(phy_wr), .phy_addr(phy_addr), .phy_wdata(phy_wdata),
    .phy_ack(phy_ack), .link_up(link_up), .link_fail(link_fail),
    .fail_snap0(fail_snap0), .fail_snap1(fail_snap1)
);

// File: tb/lw_link_watch_tb_top.sv
module lw_link_watch_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MAXC    = 4;
    localparam int HOLD    = 8;
    localparam int RECHECK = 12;
    localparam int ACK_LAT = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic [31:0] dbg0 = '0;
    logic [31:0] dbg1 = '0;
    logic        phy_req, phy_wr;
    logic [15:0] phy_addr, phy_wdata;
    logic        phy_ack = 1'b0;
    logic [15:0] phy_rdata = '0;
    logic        link_up, link_fail;
    logic [31:0] fail_snap0, fail_snap1;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // PHY model state and log
    logic [15:0] ovr_reg = 16'h0101;
    logic [15:0] rxv_reg = 16'h0000;
    int n_cmd = 0, n_rxv = 0, n_ovr_rd = 0, n_ovr_wr = 0;
    logic [15:0] wr_log [0:7];
    int t_rxv [0:7];
    int t_set_ack = 0, t_rd2 = 0;
    int cyc = 0;
    int lat = 0;
    bit seen = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    lw_link_watch #(
        .MAX_CHECKS(MAXC), .HOLD_CYC(HOLD), .RECHECK_CYC(RECHECK),
        .RCVRLOCK_CODE(6'h0D)
    ) dut_i (
        .clk(clk), .rst(rst), .enable(enable),
        .dbg_status0(dbg0), .dbg_status1(dbg1),
        .phy_req(phy_req), .phy_wr(phy_wr), .phy_addr(phy_addr),
        .phy_wdata(phy_wdata), .phy_ack(phy_ack), .phy_rdata(phy_rdata),
        .link_up(link_up), .link_fail(link_fail),
        .fail_snap0(fail_snap0), .fail_snap1(fail_snap1)
    );

    // Acknowledging PHY model, acts on falling edges
    always @(negedge clk) begin
        if (phy_ack) begin
            phy_ack = 1'b0;
            seen    = 1'b0;
        end else if (phy_req) begin
            if (!seen) begin
                seen = 1'b1;
                lat  = 0;
                n_cmd++;
                if (!phy_wr && phy_addr == 16'h100D) begin
                    if (n_rxv < 8) t_rxv[n_rxv] = cyc;
                    n_rxv++;
                end
                if (!phy_wr && phy_addr == 16'h1005) begin
                    if (n_ovr_rd == 1) t_rd2 = cyc;
                    n_ovr_rd++;
                end
            end
            if (lat == ACK_LAT) begin
                phy_ack = 1'b1;
                if (phy_wr) begin
                    if (phy_addr == 16'h1005) begin
                        ovr_reg = phy_wdata;
                        if (n_ovr_wr < 8) wr_log[n_ovr_wr] = phy_wdata;
                        if (n_ovr_wr == 0) t_set_ack = cyc;
                        n_ovr_wr++;
                    end
                end else begin
                    phy_rdata = (phy_addr == 16'h1005) ? ovr_reg :
                                (phy_addr == 16'h100D) ? rxv_reg : 16'h0000;
                end
            end else begin
                lat++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_log();
        n_cmd = 0; n_rxv = 0; n_ovr_rd = 0; n_ovr_wr = 0;
        t_set_ack = 0; t_rd2 = 0;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic go_idle();
        enable = 1'b0;
        cycles(40);
        clear_log();
    endtask

    task automatic t_reset();
        rst = 1'b1;
        cycles(3);
        // R1: outputs during and right after reset
        chk(!link_up && !link_fail, "R1", "status after reset", {link_up, link_fail}, 0);
        chk(!phy_req, "R1", "phy_req after reset", phy_req, 0);
        chk(fail_snap0 == 0 && fail_snap1 == 0, "R1", "snapshots after reset",
            fail_snap0 | fail_snap1, 0);
        rst = 1'b0;
        cycles(2);
    endtask

    task automatic t_link_present();
        dbg0 = 32'h0000_0011;
        dbg1 = 32'h0000_0010;           // R2: bit4 set, bit29 clear
        enable = 1'b1;
        cycles(6);
        chk(link_up == 1'b1, "R2", "link_up with trained link", link_up, 1);
        chk(n_cmd == 0, "R2", "no PHY command when already up", n_cmd, 0);
        // R7: later loss of the link bit does not drop link_up
        dbg1 = 32'h0000_0000;
        cycles(20);
        chk(link_up == 1'b1, "R7", "link_up sticky", link_up, 1);
        // R8: enable low clears link_up on the next cycle
        enable = 1'b0;
        cycles(2);
        chk(link_up == 1'b0, "R8", "link_up cleared by enable low", link_up, 0);
        go_idle();
    endtask

    task automatic t_training_bit();
        // R2: link bit with training bit still set is not up
        dbg0 = 32'h0000_0011;
        dbg1 = 32'h2000_0010;
        rxv_reg = 16'h0000;
        enable = 1'b1;
        cycles(10);
        chk(link_up == 1'b0, "R2", "in-training blocks link_up", link_up, 0);
        // R3: one read of 0x100D, not in recovery state -> no 0x1005 access
        chk(n_rxv == 1, "R3", "receiver status reads", n_rxv, 1);
        cycles(25);
        chk(n_ovr_rd == 0 && n_ovr_wr == 0, "R4", "no override access outside recovery state",
            n_ovr_rd + n_ovr_wr, 0);
        dbg1 = 32'h0000_0010;
        cycles(RECHECK + 20);
        chk(link_up == 1'b1, "R2", "up once training bit clears", link_up, 1);
        go_idle();
    endtask

    task automatic t_rx_valid();
        // R3/R4: recovery state but receiver valid (bit 0 = 1)
        dbg0 = 32'h0000_000D;
        dbg1 = 32'h0000_0000;
        rxv_reg = 16'h0001;
        enable = 1'b1;
        cycles(3 * (RECHECK + 12));
        chk(n_rxv >= 2, "R3", "re-checks with receiver valid", n_rxv, 2);
        chk(n_ovr_wr == 0, "R4", "no override when receiver valid", n_ovr_wr, 0);
        go_idle();
        rst = 1'b1; cycles(2); rst = 1'b0; cycles(2);
    endtask

    task automatic t_recover(input logic [15:0] orig);
        logic [15:0] exp_set, exp_clr;
        exp_set = orig | 16'h0028;
        exp_clr = exp_set & ~16'h0028;
        ovr_reg = orig;
        rxv_reg = 16'h0000;
        dbg0 = 32'hA5A5_A50D;           // state code 0x0D in bits [5:0]
        dbg1 = 32'h0000_0000;
        enable = 1'b1;
        for (int i = 0; i < 200 && n_ovr_wr < 2; i++) cycles(1);
        chk(n_ovr_wr == 2, "R4", "two override writes", n_ovr_wr, 2);
        chk(wr_log[0] == exp_set, "R4", "set write value", wr_log[0], exp_set);
        chk(wr_log[1] == exp_clr, "R4", "clear write value", wr_log[1], exp_clr);
        chk(t_rd2 - t_set_ack >= HOLD, "R4", "override hold cycles",
            t_rd2 - t_set_ack, HOLD);
        dbg1 = 32'h0000_0010;
        cycles(RECHECK + 20);
        chk(link_up == 1'b1, "R4", "link up after recovery", link_up, 1);
        go_idle();
        rst = 1'b1; cycles(2); rst = 1'b0; cycles(2);
    endtask

    task automatic t_exhaust();
        dbg0 = 32'h1234_5603;
        dbg1 = 32'h2000_0010;
        rxv_reg = 16'h0000;
        enable = 1'b1;
        for (int i = 0; i < 400 && !link_fail; i++) cycles(1);
        chk(link_fail == 1'b1, "R6", "link_fail after budget", link_fail, 1);
        chk(n_rxv == MAXC - 1, "R6", "checks that read status", n_rxv, MAXC - 1);
        chk(fail_snap0 == 32'h1234_5603, "R6", "snapshot word 0", fail_snap0, 32'h1234_5603);
        chk(fail_snap1 == 32'h2000_0010, "R6", "snapshot word 1", fail_snap1, 32'h2000_0010);
        chk(t_rxv[1] - t_rxv[0] >= RECHECK, "R5", "re-check spacing",
            t_rxv[1] - t_rxv[0], RECHECK);
        chk(t_rxv[2] - t_rxv[1] >= RECHECK, "R5", "re-check spacing 2",
            t_rxv[2] - t_rxv[1], RECHECK);
        chk(!link_up, "R10", "no link_up with link_fail", link_up, 0);
        dbg0 = 32'h0;
        dbg1 = 32'h0;
        cycles(5);
        chk(n_rxv == MAXC - 1, "R6", "no command after fail", n_rxv, MAXC - 1);
        enable = 1'b0;
        cycles(2);
        chk(link_fail == 1'b0, "R8", "link_fail cleared by enable low", link_fail, 0);
        chk(fail_snap0 == 32'h1234_5603 && fail_snap1 == 32'h2000_0010, "R6",
            "snapshot held after enable low", fail_snap0, 32'h1234_5603);
        go_idle();
    endtask

    task automatic t_drop_mid();
        int rx_before;
        ovr_reg = 16'h0101;
        rxv_reg = 16'h0000;
        dbg0 = 32'h0000_000D;
        dbg1 = 32'h0000_0000;
        enable = 1'b1;
        for (int i = 0; i < 200 && n_ovr_wr < 1; i++) cycles(1);
        rx_before = n_rxv;
        enable = 1'b0;                  // withdraw during hold
        cycles(60);
        chk(n_ovr_wr == 2, "R8", "clear write completes after enable low", n_ovr_wr, 2);
        chk(wr_log[1] == 16'h0101, "R8", "override released", wr_log[1], 16'h0101);
        chk(n_rxv == rx_before, "R8", "no check after enable low", n_rxv, rx_before);
        chk(!phy_req && !link_up && !link_fail, "R8", "quiet after withdrawal",
            {phy_req, link_up, link_fail}, 0);
        go_idle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_link_present();
        t_training_bit();
        t_rx_valid();
        t_recover(16'h0101);
        t_recover(16'hFFD7);
        t_exhaust();
        t_drop_mid();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule